// File: doc/BRIEF.md
# Multi-Context Streaming Address Generator

This block sits beside one scratchpad SRAM port and generates addresses for that port. Software does not compute each address. It programs a context with a pattern description: a start address, a step taken between elements of a row, the number of elements in a row, a step taken between rows, and the number of rows. After that, each load or store request gives only a context index. The block returns the address that this context has reached and moves the context on to its next element. A one-dimensional vector walk is a two-dimensional walk that has a single row.

The block holds several contexts, and each one keeps its own parameters and progress. Requests can therefore interleave several streams through the same port in any order. A loop-start pulse moves every context back to its start address and leaves the parameters as they are, so the same patterns can be used again in the next loop. Requests enter through a valid/ready handshake. Responses leave through a registered valid/ready stage. When a response is stalled, the request side stops accepting until the response is consumed. Configuration writes and the loop-start pulse are plain control inputs and are always accepted.

Top module: `stream_agen`

## Requirements
- R1: After reset, `rsp_valid` is 0, `ctx_done` is all zeros, and `req_ready` is 1.
- R2: A configuration write stores the start address, both strides and both count fields into context `cfg_idx`. A count field holds the number of elements (or rows) minus one. The next access to that context returns the start address.
- R3: When an access is not the last element of its row, the context's next address is the current address plus the inner stride, modulo 2^16.
- R4: After the last element of a row, the context's next address is that row's first address plus the outer stride, and the element position goes back to zero.
- R5: The access that returns the last element of the last row sends the context back to its start address. It also raises bit `idx` of `ctx_done` for exactly one cycle, in the same cycle as that response. `ctx_done` never has more than one bit set.
- R6: An access moves only the context it names. All other contexts keep their position.
- R7: A `loop_start` pulse moves every context back to its start address, with element and row positions at zero, and keeps the parameters. An access accepted in the same cycle as the pulse returns the start address.
- R8: If a configuration write and an accepted access target the same context in the same cycle, the access returns the newly written start address, and the walk continues from the new pattern.
- R9: A request is accepted when `req_valid` and `req_ready` are both 1. Its response appears on the next cycle, with `rsp_valid` set to 1 and `rsp_idx` equal to the requested index.
- R10: While `rsp_valid` is 1 and `rsp_ready` is 0, `req_ready` is 0, `rsp_addr` and `rsp_idx` hold their values, and no context advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Context that the write targets |
| cfg_base | input | 16 | Start address |
| cfg_istride | input | 16 | Step between elements of a row |
| cfg_icount | input | 16 | Elements per row minus one |
| cfg_ostride | input | 16 | Step between row starts |
| cfg_ocount | input | 16 | Rows minus one |
| loop_start | input | 1 | Rewind all contexts |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Access request can be taken |
| req_idx | input | 3 | Context index of the request |
| rsp_valid | output | 1 | Response address present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_addr | output | 16 | Generated address |
| rsp_idx | output | 3 | Context that produced the address |
| ctx_done | output | 8 | One-cycle pattern-complete flag, one bit per context |

## Verification
The hardest cases to reach from the ports are collisions: a configuration write, a loop-start pulse and an accepted access all landing in one cycle, or a request that waits behind a stalled response. Each of these changes which state the returned address comes from. The stimulus first walks two interleaved patterns through a table of vectors. One pattern wraps its address past 0xFFFF. Directed sequences then line up a write or a rewind on the same edge as an access. A final sequence holds `rsp_ready` low while a request is pending and confirms that the context resumes at the element it had reached.

// File: rtl/agen_pkg.sv
package agen_pkg;
  typedef enum logic [1:0] {
    STEP_INNER = 2'd0,
    STEP_ROW   = 2'd1,
    STEP_WRAP  = 2'd2
  } step_e;
endpackage

// File: rtl/agen_step.sv
module agen_step
  import agen_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] cur_i,
  input  logic [AW-1:0] row_i,
  input  logic [CW-1:0] ipos_i,
  input  logic [CW-1:0] opos_i,
  input  logic [AW-1:0] istr_i,
  input  logic [CW-1:0] ilim_i,
  input  logic [AW-1:0] ostr_i,
  input  logic [CW-1:0] olim_i,
  output logic [AW-1:0] cur_o,
  output logic [AW-1:0] row_o,
  output logic [CW-1:0] ipos_o,
  output logic [CW-1:0] opos_o,
  output step_e         kind_o
);
  logic row_end, col_end;
  logic [AW-1:0] next_row;

  assign row_end  = (ipos_i == ilim_i);
  assign col_end  = (opos_i == olim_i);
  assign next_row = row_i + ostr_i;

  always_comb begin
    if (!row_end) begin
      kind_o = STEP_INNER;
      cur_o  = cur_i + istr_i;
      row_o  = row_i;
      ipos_o = ipos_i + CW'(1);
      opos_o = opos_i;
    end else if (!col_end) begin
      kind_o = STEP_ROW;
      cur_o  = next_row;
      row_o  = next_row;
      ipos_o = '0;
      opos_o = opos_i + CW'(1);
    end else begin
      kind_o = STEP_WRAP;
      cur_o  = base_i;
      row_o  = base_i;
      ipos_o = '0;
      opos_o = '0;
    end
  end
endmodule

// File: rtl/agen_ctx_slot.sv
module agen_ctx_slot
  import agen_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_base,
  input  logic [AW-1:0] cfg_istride,
  input  logic [CW-1:0] cfg_icount,
  input  logic [AW-1:0] cfg_ostride,
  input  logic [CW-1:0] cfg_ocount,
  input  logic          rewind,
  input  logic          adv,
  output logic [AW-1:0] addr_o,
  output logic          wrap_o
);
  logic [AW-1:0] base_q, istr_q, ostr_q, cur_q, row_q;
  logic [CW-1:0] ilim_q, olim_q, ipos_q, opos_q;

  logic [AW-1:0] base_e, istr_e, ostr_e, cur_e, row_e;
  logic [CW-1:0] ilim_e, olim_e, ipos_e, opos_e;
  logic          fresh;

  logic [AW-1:0] cur_n, row_n;
  logic [CW-1:0] ipos_n, opos_n;
  step_e         kind;

  // a write or rewind in this cycle is seen by a same-cycle access
  assign fresh  = cfg_we | rewind;
  assign base_e = cfg_we ? cfg_base    : base_q;
  assign istr_e = cfg_we ? cfg_istride : istr_q;
  assign ostr_e = cfg_we ? cfg_ostride : ostr_q;
  assign ilim_e = cfg_we ? cfg_icount  : ilim_q;
  assign olim_e = cfg_we ? cfg_ocount  : olim_q;
  assign cur_e  = fresh ? base_e : cur_q;
  assign row_e  = fresh ? base_e : row_q;
  assign ipos_e = fresh ? '0 : ipos_q;
  assign opos_e = fresh ? '0 : opos_q;

  agen_step #(.AW(AW), .CW(CW)) step_i (
    .base_i (base_e), .cur_i (cur_e), .row_i (row_e),
    .ipos_i (ipos_e), .opos_i (opos_e),
    .istr_i (istr_e), .ilim_i (ilim_e),
    .ostr_i (ostr_e), .olim_i (olim_e),
    .cur_o  (cur_n),  .row_o (row_n),
    .ipos_o (ipos_n), .opos_o (opos_n),
    .kind_o (kind)
  );

  assign addr_o = cur_e;
  assign wrap_o = (kind == STEP_WRAP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0; istr_q <= '0; ostr_q <= '0;
      ilim_q <= '0; olim_q <= '0;
    end else if (cfg_we) begin
      base_q <= cfg_base;    istr_q <= cfg_istride;
      ostr_q <= cfg_ostride; ilim_q <= cfg_icount;
      olim_q <= cfg_ocount;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q <= '0; row_q <= '0; ipos_q <= '0; opos_q <= '0;
    end else if (adv) begin
      cur_q <= cur_n; row_q <= row_n; ipos_q <= ipos_n; opos_q <= opos_n;
    end else if (fresh) begin
      cur_q <= base_e; row_q <= base_e; ipos_q <= '0; opos_q <= '0;
    end
  end

  // R3
  inner_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !fresh && ipos_q != ilim_q) |=> (cur_q == $past(cur_q) + $past(istr_q)));

  // R7
  rewind_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rewind && !adv && !cfg_we) |=> (cur_q == base_q && ipos_q == '0 && opos_q == '0));

  // R5
  wrap_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && wrap_o) |=> (cur_q == base_q && ipos_q == '0));
endmodule

// File: rtl/agen_rsp_stage.sv
module agen_rsp_stage #(
  parameter int AW      = 16,
  parameter int IW      = 3,
  parameter int NUM_CTX = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [IW-1:0]      idx_i,
  input  logic               wrap_i,
  input  logic               rsp_ready,
  output logic               ready_o,
  output logic               rsp_valid,
  output logic [AW-1:0]      rsp_addr,
  output logic [IW-1:0]      rsp_idx,
  output logic [NUM_CTX-1:0] done_o
);
  assign ready_o = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      rsp_idx   <= '0;
      done_o    <= '0;
    end else begin
      done_o <= (accept_i && wrap_i) ? (NUM_CTX'(1) << idx_i) : '0;
      if (accept_i) begin
        rsp_valid <= 1'b1;
        rsp_addr  <= addr_i;
        rsp_idx   <= idx_i;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) && $stable(rsp_idx)));

  // R9
  one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_i |=> rsp_valid);

  // R5
  done_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done_o));

  // R5
  done_with_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|done_o) |-> rsp_valid);
endmodule

// File: rtl/stream_agen.sv
module stream_agen #(
  parameter int NUM_CTX = 8,
  parameter int AW      = 16,
  parameter int CW      = 16,
  localparam int IW     = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [IW-1:0]      cfg_idx,
  input  logic [AW-1:0]      cfg_base,
  input  logic [AW-1:0]      cfg_istride,
  input  logic [CW-1:0]      cfg_icount,
  input  logic [AW-1:0]      cfg_ostride,
  input  logic [CW-1:0]      cfg_ocount,
  input  logic               loop_start,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [IW-1:0]      req_idx,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [AW-1:0]      rsp_addr,
  output logic [IW-1:0]      rsp_idx,
  output logic [NUM_CTX-1:0] ctx_done
);
  logic               accept;
  logic [AW-1:0]      slot_addr [NUM_CTX];
  logic [NUM_CTX-1:0] slot_wrap;
  logic [NUM_CTX-1:0] slot_adv;
  logic [AW-1:0]      sel_addr;
  logic               sel_wrap;

  assign accept = req_valid && req_ready;

  for (genvar g = 0; g < NUM_CTX; g++) begin : g_slot
    assign slot_adv[g] = accept && (req_idx == IW'(g));
    agen_ctx_slot #(.AW(AW), .CW(CW)) slot_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_we      (cfg_we && (cfg_idx == IW'(g))),
      .cfg_base    (cfg_base),
      .cfg_istride (cfg_istride),
      .cfg_icount  (cfg_icount),
      .cfg_ostride (cfg_ostride),
      .cfg_ocount  (cfg_ocount),
      .rewind      (loop_start),
      .adv         (slot_adv[g]),
      .addr_o      (slot_addr[g]),
      .wrap_o      (slot_wrap[g])
    );
  end

  assign sel_addr = slot_addr[req_idx];
  assign sel_wrap = slot_wrap[req_idx];

  agen_rsp_stage #(.AW(AW), .IW(IW), .NUM_CTX(NUM_CTX)) rsp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept_i  (accept),
    .addr_i    (sel_addr),
    .idx_i     (req_idx),
    .wrap_i    (sel_wrap),
    .rsp_ready (rsp_ready),
    .ready_o   (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_addr  (rsp_addr),
    .rsp_idx   (rsp_idx),
    .done_o    (ctx_done)
  );

  // R6
  single_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_adv));
endmodule

// File: tb/stream_agen_tb_top.sv
module stream_agen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [15:0] cfg_base = '0, cfg_istride = '0, cfg_icount = '0;
  logic [15:0] cfg_ostride = '0, cfg_ocount = '0;
  logic        loop_start = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_idx = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [15:0] rsp_addr;
  logic [2:0]  rsp_idx;
  logic [7:0]  ctx_done;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  stream_agen dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base),
    .cfg_istride(cfg_istride), .cfg_icount(cfg_icount),
    .cfg_ostride(cfg_ostride), .cfg_ocount(cfg_ocount),
    .loop_start(loop_start),
    .req_valid(req_valid), .req_ready(req_ready), .req_idx(req_idx),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_addr(rsp_addr), .rsp_idx(rsp_idx), .ctx_done(ctx_done)
  );

  typedef struct packed {
    logic [2:0]  idx;
    logic [15:0] addr;
    logic        done;
  } vec_t;

  // ctx0: base 0100, istride 4, 3 per row, ostride 40, 2 rows
  // ctx3: base FFF0, istride 8, 4 elements, single row (wraps past FFFF)
  localparam vec_t VEC [12] = '{
    '{3'd0, 16'h0100, 1'b0}, '{3'd3, 16'hFFF0, 1'b0},
    '{3'd0, 16'h0104, 1'b0}, '{3'd0, 16'h0108, 1'b0},
    '{3'd3, 16'hFFF8, 1'b0}, '{3'd0, 16'h0140, 1'b0},
    '{3'd3, 16'h0000, 1'b0}, '{3'd3, 16'h0008, 1'b1},
    '{3'd0, 16'h0144, 1'b0}, '{3'd0, 16'h0148, 1'b1},
    '{3'd0, 16'h0100, 1'b0}, '{3'd3, 16'hFFF0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic configure(input logic [2:0] i, input logic [15:0] b, input logic [15:0] is,
                           input logic [15:0] ic, input logic [15:0] os, input logic [15:0] oc);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = i; cfg_base = b; cfg_istride = is;
    cfg_icount = ic; cfg_ostride = os; cfg_ocount = oc;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // issue one access, sample its response just after the accepting edge
  task automatic access(input logic [2:0] i, input logic with_loop, input logic with_cfg);
    @(negedge clk);
    req_valid = 1'b1; req_idx = i;
    loop_start = with_loop;
    if (with_cfg) cfg_we = 1'b1;
    @(posedge clk);
    #1;
    @(negedge clk);
    req_valid = 1'b0; loop_start = 1'b0; cfg_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 outputs held in reset
    check("R1 rsp_valid", 32'(rsp_valid), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 req_ready", 32'(req_ready), 32'd1);
    check("R1 ctx_done", 32'(ctx_done), 32'd0);

    // R2 program two contexts
    configure(3'd0, 16'h0100, 16'h0004, 16'd2, 16'h0040, 16'd1);
    configure(3'd3, 16'hFFF0, 16'h0008, 16'd3, 16'h0000, 16'd0);

    // table walk: R2 R3 R4 R5 R6 R9
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      req_valid = 1'b1; req_idx = VEC[k].idx;
      @(posedge clk); #1;
      check("R9 rsp_valid", 32'(rsp_valid), 32'd1);
      check("R9 rsp_idx", 32'(rsp_idx), 32'(VEC[k].idx));
      check("R3/R4/R6 rsp_addr", 32'(rsp_addr), 32'(VEC[k].addr));
      check("R5 ctx_done", 32'(ctx_done), VEC[k].done ? (32'd1 << VEC[k].idx) : 32'd0);
      @(negedge clk);
      req_valid = 1'b0;
      @(posedge clk); #1;
      check("R5 done one cycle", 32'(ctx_done), 32'd0);
    end

    // R7 loop_start alone, then accesses return base
    // ctx0 now at 0104, ctx3 at FFF8
    @(negedge clk); loop_start = 1'b1;
    @(negedge clk); loop_start = 1'b0;
    access(3'd0, 1'b0, 1'b0);
    check("R7 ctx0 rewound", 32'(rsp_addr), 32'h0100);
    access(3'd3, 1'b0, 1'b0);
    check("R7 ctx3 rewound", 32'(rsp_addr), 32'hFFF0);
    // R7 loop_start with an access in the same cycle
    access(3'd0, 1'b1, 1'b0);
    check("R7 same-cycle rewind", 32'(rsp_addr), 32'h0100);
    access(3'd0, 1'b0, 1'b0);
    check("R7 continue after rewind", 32'(rsp_addr), 32'h0104);

    // R8 config and access to ctx5 in the same cycle
    cfg_idx = 3'd5; cfg_base = 16'h2000; cfg_istride = 16'h0002;
    cfg_icount = 16'd1; cfg_ostride = 16'h0000; cfg_ocount = 16'd0;
    access(3'd5, 1'b0, 1'b1);
    check("R8 collision returns new base", 32'(rsp_addr), 32'h2000);
    access(3'd5, 1'b0, 1'b0);
    check("R8 walk follows new pattern", 32'(rsp_addr), 32'h2002);
    check("R5 ctx5 done bit", 32'(ctx_done), 32'h20);

    // R10 back-pressure with a pending request
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_idx = 3'd5;
    @(posedge clk); #1;
    check("R10 first rsp", 32'(rsp_addr), 32'h2000);
    check("R10 req_ready low", 32'(req_ready), 32'd0);
    @(posedge clk); #1;
    check("R10 rsp held", 32'(rsp_addr), 32'h2000);
    check("R10 rsp_valid held", 32'(rsp_valid), 32'd1);
    @(negedge clk);
    rsp_ready = 1'b1;
    @(posedge clk); #1;
    check("R10 no advance during stall", 32'(rsp_addr), 32'h2002);
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk); #1;
    check("R9 rsp drained", 32'(rsp_valid), 32'd0);

    finish_run();
  end
endmodule